// File: doc/BRIEF.md
# PRG Bank and Single-Screen Mapper

This block sits between a console's CPU and PPU buses and the cartridge memories. One register, loaded by any CPU write to the upper half of the CPU address space, holds two selections at once. The first is a 32 KB program bank, which forms the top bits of the program ROM address. The second is a single nametable page bit, which picks one 1 KB half of the console's 2 KB internal video RAM.

All four nametable windows in 0x2000–0x2FFF fold onto that one page, which gives single-screen mirroring that software can switch at run time. Pattern accesses in 0x0000–0x1FFF pass unchanged to CHR memory. The bench models the ROM and RAM themselves. Address outputs and enables are combinational from the bus inputs and the registered selections. A register write therefore takes effect on the cycle after the clock edge that captures it.

Top module: `prg_screen_mapper`

## Requirements
- R1: After reset the PRG bank is 0 and the nametable page is 0, so `prg_addr[17:15]` and `nt_addr[10]` read 0.
- R2: A CPU write with `cpu_addr[15]`=1 loads the register on the next rising clock edge. A CPU write with `cpu_addr[15]`=0 changes neither selection.
- R3: Data bits [2:0] of a register write become the PRG bank. The bank appears on `prg_addr[17:15]`, so there are eight 32 KB banks.
- R4: Data bit 4 of a register write becomes the nametable page, driven on `nt_addr[10]`.
- R5: Data bits 3, 5, 6 and 7 of a register write affect neither selection.
- R6: `prg_addr[14:0]` equals `cpu_addr[14:0]`. `prg_rd` is high exactly when `cpu_rd`=1 and `cpu_addr[15]`=1.
- R7: `nt_addr[9:0]` equals `ppu_addr[9:0]`. All four 1 KB windows at 0x2000, 0x2400, 0x2800 and 0x2C00 map to the same RAM word, and offset 0x3FF is reachable.
- R8: For `ppu_addr` below 0x2000, `chr_addr` equals `ppu_addr[12:0]`, and `chr_rd` and `chr_wr` follow `ppu_rd` and `ppu_wr`. There is no banking.
- R9: `nt_rd` and `nt_wr` are asserted only for PPU reads or writes in 0x2000–0x2FFF. They stay low at 0x3000 and above and for pattern accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| ppu_addr | input | 14 | PPU address |
| ppu_rd | input | 1 | PPU read strobe |
| ppu_wr | input | 1 | PPU write strobe |
| prg_addr | output | 18 | Program ROM address |
| prg_rd | output | 1 | Program ROM read enable |
| chr_addr | output | 13 | CHR memory address |
| chr_rd | output | 1 | CHR read enable |
| chr_wr | output | 1 | CHR write enable |
| nt_addr | output | 11 | Internal nametable RAM address |
| nt_rd | output | 1 | Nametable RAM read enable |
| nt_wr | output | 1 | Nametable RAM write enable |

## Verification
The bench builds the block with its default of three bank bits. This brings all eight 32 KB banks within reach, and each one is selected and read back at both ends of the CPU window. Writes with every ignored data bit set, and writes below 0x8000, show that neither selection moves. Both page values are combined with the four nametable windows and with offsets 0x000 and 0x3FF, which covers aliasing and the reachability of the last word.

// File: rtl/mapper_pkg.sv
// Shared constants for the PRG bank / single-screen mapper.
// Assumes an 8-bit CPU data bus, a 16-bit CPU address and a 14-bit PPU address.
package mapper_pkg;
    localparam int CPU_AW      = 16;
    localparam int PPU_AW      = 14;
    localparam int DATA_W      = 8;
    localparam int PRG_OFS_W   = 15;   // 32 KB window offset
    localparam int CHR_AW      = 13;   // 8 KB pattern space
    localparam int NT_OFS_W    = 10;   // 1 KB page
    localparam int NT_AW       = NT_OFS_W + 1;
    localparam int PAGE_BIT    = 4;    // data bit holding the page select

    // Region of the PPU address space a cycle falls in
    typedef enum logic [1:0] {
        REG_CHR  = 2'd0,
        REG_NT   = 2'd1,
        REG_NONE = 2'd2
    } ppu_region_e;
endpackage

// File: rtl/mapper_ctrl_reg.sv
// Control register: holds the PRG bank and the nametable page.
// Assumes wr_en is already decoded to the register's address window.
// Data bits other than [BANK_W-1:0] and PAGE_BIT are dropped.
module mapper_ctrl_reg
    import mapper_pkg::*;
#(
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [BANK_W-1:0] bank,
    output logic              page
);
    // Capture bank and page on a decoded write, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank <= '0;
            page <= 1'b0;
        end else if (wr_en) begin
            bank <= wdata[BANK_W-1:0];
            page <= wdata[PAGE_BIT];
        end
    end
endmodule

// File: rtl/prg_addr_map.sv
// Builds the program ROM address from the bank and the 32 KB CPU offset.
// Assumes the ROM occupies CPU 0x8000-0xFFFF (address bit 15 set).
module prg_addr_map
    import mapper_pkg::*;
#(
    parameter int BANK_W = 3,
    localparam int PRG_AW = BANK_W + PRG_OFS_W
) (
    input  logic              cpu_rd,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [BANK_W-1:0] bank,
    output logic [PRG_AW-1:0] prg_addr,
    output logic              prg_rd
);
    // Bank on top, window offset below; read enable limited to the ROM window
    always_comb begin
        prg_addr = {bank, cpu_addr[PRG_OFS_W-1:0]};
        prg_rd   = cpu_rd & cpu_addr[CPU_AW-1];
    end
endmodule

// File: rtl/ppu_space_decode.sv
// Splits PPU cycles into pattern (CHR) and nametable accesses.
// Pattern space passes through unbanked; every nametable window folds onto
// the selected 1 KB page. Addresses at 0x3000 and above enable nothing.
module ppu_space_decode
    import mapper_pkg::*;
(
    input  logic              ppu_rd,
    input  logic              ppu_wr,
    input  logic [PPU_AW-1:0] ppu_addr,
    input  logic              page,
    output logic [CHR_AW-1:0] chr_addr,
    output logic              chr_rd,
    output logic              chr_wr,
    output logic [NT_AW-1:0]  nt_addr,
    output logic              nt_rd,
    output logic              nt_wr
);
    ppu_region_e region;

    // Classify the address by its top two bits
    always_comb begin
        unique case (ppu_addr[PPU_AW-1:PPU_AW-2])
            2'b00, 2'b01: region = REG_CHR;
            2'b10:        region = REG_NT;
            default:      region = REG_NONE;
        endcase
    end

    // Drive addresses and strobes for the selected memory
    always_comb begin
        chr_addr = ppu_addr[CHR_AW-1:0];
        nt_addr  = {page, ppu_addr[NT_OFS_W-1:0]};
        chr_rd   = ppu_rd & (region == REG_CHR);
        chr_wr   = ppu_wr & (region == REG_CHR);
        nt_rd    = ppu_rd & (region == REG_NT);
        nt_wr    = ppu_wr & (region == REG_NT);
    end
endmodule

// File: rtl/prg_screen_mapper.sv
// Top of the PRG bank / single-screen mapper.
// A CPU write in 0x8000-0xFFFF loads bank and page; outputs are combinational
// from the bus inputs and the registered selections.
module prg_screen_mapper
    import mapper_pkg::*;
#(
    parameter int BANK_W = 3,
    localparam int PRG_AW = BANK_W + PRG_OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [PPU_AW-1:0] ppu_addr,
    input  logic              ppu_rd,
    input  logic              ppu_wr,
    output logic [PRG_AW-1:0] prg_addr,
    output logic              prg_rd,
    output logic [CHR_AW-1:0] chr_addr,
    output logic              chr_rd,
    output logic              chr_wr,
    output logic [NT_AW-1:0]  nt_addr,
    output logic              nt_rd,
    output logic              nt_wr
);
    logic              reg_wr;
    logic [BANK_W-1:0] bank;
    logic              page;

    // Register write decode: any write into the upper CPU half
    always_comb reg_wr = cpu_wr & cpu_addr[CPU_AW-1];

    mapper_ctrl_reg #(.BANK_W(BANK_W)) i_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr),
        .wdata (cpu_wdata),
        .bank  (bank),
        .page  (page)
    );

    prg_addr_map #(.BANK_W(BANK_W)) i_prg (
        .cpu_rd   (cpu_rd),
        .cpu_addr (cpu_addr),
        .bank     (bank),
        .prg_addr (prg_addr),
        .prg_rd   (prg_rd)
    );

    ppu_space_decode i_ppu (
        .ppu_rd   (ppu_rd),
        .ppu_wr   (ppu_wr),
        .ppu_addr (ppu_addr),
        .page     (page),
        .chr_addr (chr_addr),
        .chr_rd   (chr_rd),
        .chr_wr   (chr_wr),
        .nt_addr  (nt_addr),
        .nt_rd    (nt_rd),
        .nt_wr    (nt_wr)
    );
endmodule

// File: rtl/mapper_checker.sv
// Port-level properties of prg_screen_mapper, attached by bind.
module mapper_checker
    import mapper_pkg::*;
#(
    parameter int BANK_W = 3,
    localparam int PRG_AW = BANK_W + PRG_OFS_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CPU_AW-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic              cpu_wr,
    input logic [PPU_AW-1:0] ppu_addr,
    input logic              ppu_wr,
    input logic [PRG_AW-1:0] prg_addr,
    input logic              prg_rd,
    input logic              chr_wr,
    input logic [NT_AW-1:0]  nt_addr,
    input logic              nt_wr
);
    AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[CPU_AW-1]) |=> prg_addr[PRG_AW-1:PRG_OFS_W] == $past(cpu_wdata[BANK_W-1:0])); // R3
    AST_PAGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[CPU_AW-1]) |=> nt_addr[NT_OFS_W] == $past(cpu_wdata[PAGE_BIT])); // R4
    AST_LOW_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cpu_wr && cpu_addr[CPU_AW-1])) |=> $stable(prg_addr[PRG_AW-1:PRG_OFS_W]) && $stable(nt_addr[NT_OFS_W])); // R2
    AST_NT_WE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        nt_wr |-> (ppu_wr && ppu_addr[PPU_AW-1:PPU_AW-2] == 2'b10)); // R9
    AST_WE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({nt_wr, chr_wr})); // R8
    AST_PRG_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        prg_rd |-> cpu_addr[CPU_AW-1]); // R6
endmodule

bind prg_screen_mapper mapper_checker #(.BANK_W(BANK_W)) i_mapper_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_wr    (cpu_wr),
    .ppu_addr  (ppu_addr),
    .ppu_wr    (ppu_wr),
    .prg_addr  (prg_addr),
    .prg_rd    (prg_rd),
    .chr_wr    (chr_wr),
    .nt_addr   (nt_addr),
    .nt_wr     (nt_wr)
);

// File: tb/test_prg_screen_mapper.sv
// Directed bench for prg_screen_mapper; one task per scenario.
module test_prg_screen_mapper;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_wdata;
    logic        cpu_rd, cpu_wr;
    logic [13:0] ppu_addr;
    logic        ppu_rd, ppu_wr;
    logic [17:0] prg_addr;
    logic        prg_rd;
    logic [12:0] chr_addr;
    logic        chr_rd, chr_wr;
    logic [10:0] nt_addr;
    logic        nt_rd, nt_wr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    prg_screen_mapper i_prg_screen_mapper (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Register write through the CPU bus, then settle after the capturing edge
    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        cpu_addr = 16'h8123; ppu_addr = 14'h2155; #1;
        chk(prg_addr == 18'h00123, "R1 bank", prg_addr, 18'h00123);
        chk(nt_addr[10] == 1'b0, "R1 page", nt_addr, 11'h155);
    endtask

    task automatic t_banks;
        for (int b = 0; b < 8; b++) begin
            cpu_write(16'hFFFF, 8'(b));
            cpu_rd = 1'b1; cpu_addr = 16'h8000; #1;
            chk(prg_addr == {3'(b), 15'h0000} && prg_rd, "R3 low", prg_addr, {3'(b), 15'h0000});
            cpu_addr = 16'hFFFF; #1;
            chk(prg_addr == {3'(b), 15'h7FFF}, "R6 high", prg_addr, {3'(b), 15'h7FFF});
            cpu_rd = 1'b0;
        end
    endtask

    task automatic t_prg_enable;
        cpu_rd = 1'b1; cpu_addr = 16'h7FFF; #1;
        chk(!prg_rd, "R6 below window", prg_rd, 0);
        cpu_rd = 1'b0; cpu_addr = 16'h9000; #1;
        chk(!prg_rd, "R6 no strobe", prg_rd, 0);
    endtask

    task automatic t_ignored_bits;
        cpu_write(16'h8000, 8'hE8 | 8'h05);
        cpu_addr = 16'h8000; ppu_addr = 14'h2000; #1;
        chk(prg_addr[17:15] == 3'd5, "R5 bank", prg_addr[17:15], 5);
        chk(nt_addr[10] == 1'b0, "R5 page", nt_addr[10], 0);
    endtask

    task automatic t_low_write;
        cpu_write(16'h8000, 8'h12);
        cpu_write(16'h7FFF, 8'h15);
        cpu_addr = 16'h8000; ppu_addr = 14'h2000; #1;
        chk(prg_addr[17:15] == 3'd2, "R2 bank kept", prg_addr[17:15], 2);
        chk(nt_addr[10] == 1'b1, "R2 page kept", nt_addr[10], 1);
    endtask

    task automatic t_alias;
        for (int p = 0; p < 2; p++) begin
            cpu_write(16'hC000, p[0] ? 8'h10 : 8'h00);
            chk(nt_addr[10] == p[0], "R4 page", nt_addr[10], p);
            for (int w = 0; w < 4; w++) begin
                ppu_addr = 14'h2000 + 14'(w * 16'h400) + 14'h3FF; ppu_rd = 1'b1; #1;
                chk(nt_addr == {p[0], 10'h3FF} && nt_rd, "R7 top", nt_addr, {p[0], 10'h3FF});
                ppu_addr = 14'h2000 + 14'(w * 16'h400); #1;
                chk(nt_addr == {p[0], 10'h000}, "R7 base", nt_addr, {p[0], 10'h000});
                ppu_rd = 1'b0;
            end
        end
    endtask

    task automatic t_chr;
        cpu_write(16'h8000, 8'h17);
        ppu_addr = 14'h1ABC; ppu_wr = 1'b1; #1;
        chk(chr_addr == 13'h1ABC && chr_wr && !nt_wr, "R8 write", chr_addr, 13'h1ABC);
        ppu_wr = 1'b0; ppu_rd = 1'b1; ppu_addr = 14'h0000; #1;
        chk(chr_addr == 13'h0000 && chr_rd && !nt_rd, "R8 read", chr_addr, 0);
        ppu_rd = 1'b0;
    endtask

    task automatic t_nt_enables;
        ppu_addr = 14'h2C10; ppu_wr = 1'b1; #1;
        chk(nt_wr && !chr_wr, "R9 in window", nt_wr, 1);
        ppu_addr = 14'h3000; #1;
        chk(!nt_wr && !chr_wr, "R9 above", nt_wr, 0);
        ppu_wr = 1'b0; ppu_rd = 1'b1; ppu_addr = 14'h3F00; #1;
        chk(!nt_rd && !chr_rd, "R9 read above", nt_rd, 0);
        ppu_rd = 1'b0; ppu_addr = 14'h2400; #1;
        chk(!nt_rd && !nt_wr, "R9 no strobe", nt_rd, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cpu_addr = '0; cpu_wdata = '0; cpu_rd = 1'b0; cpu_wr = 1'b0;
        ppu_addr = '0; ppu_rd = 1'b0; ppu_wr = 1'b0;
        t_reset();
        t_banks();
        t_prg_enable();
        t_ignored_bits();
        t_low_write();
        t_alias();
        t_chr();
        t_nt_enables();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule